// File: doc/BRIEF.md
# Display Controller Register and Interrupt Unit

This block is the software-visible face of a display controller. A processor reaches it through a simple 32-bit bus that carries a byte offset, a write strobe and write data, and it reads back through a combinational data port. The block holds the panel control words, the frame-buffer base and stride words, the colour lookup words, a dither word, a temporary palette word, and a 256-entry by 16-bit palette RAM. The block fetches no pixels and generates no panel timing.

The block decodes the fields that the downstream display engine needs: the enable flag, the pixel-depth mode, the 5:6:5 palette format flag and the MSB-first flag. It sends the engine a one-cycle invalidate pulse when a write changes the image geometry or its content. It sends a one-cycle palette-reload pulse when a write changes how palette colours are formed.

A small interrupt unit with two sources is also part of the block. When the engine reports a frame-sync event, the block sets a source-pending bit. Source bits move into the sticky interrupt-pending register only on a frame event or a mask write, and only where the mask is clear. The interrupt output is high while any interrupt-pending bit is set.

Top module: `disp_regbank`

## Requirements
- R1: After reset, every register reads zero except the mask word (offset 0x5C), which reads 3, and the select word (offset 0x60), which reads 4. After reset `irq`, `disp_on`, `depth_mode`, `pal565`, `msb_first`, `invalidate` and `pal_reload` are all low.
- R2: The following registers store and read back all 32 bits of a write: control words 2 and 3 (0x04, 0x08), frame-buffer words 1 to 3 (0x14, 0x18, 0x1C), red and green lookup (0x20, 0x24), dither (0x4C) and temporary palette (0x50).
- R3: Each of the following registers keeps only some bits of a write, and its other bits read as zero. Control 1 (0x00) keeps bits 17:0. Control 4 (0x0C) keeps bits 15:0. Control 5 (0x10) keeps bits 12:0. Blue lookup (0x28) keeps bits 15:0. Interrupt pending (0x54) and source pending (0x58) keep bits 1:0. The mask (0x5C) keeps bits 2:0.
- R4: The select word (0x60) stores bits 1:0 of a write and always reads bit 2 as 1.
- R5: Offsets 0x400 to 0x5FF form the palette window. Entry (offset - 0x400) >> 1 stores bits 15:0 of a write, so the even and the odd byte offset reach the same entry. A palette read returns the entry in bits 15:0 and zero above.
- R6: An offset outside the map reads zero and a write to it changes nothing. This includes register offsets that are not a multiple of 4 and offsets at or above 0x600.
- R7: `disp_on` is control 1 bit 0 and `depth_mode` is control 1 bits 4:1. `pal565` is control 5 bit 11 and `msb_first` is control 5 bit 12.
- R8: A mask write ORs (source pending AND NOT the new mask, bits 1:0) into interrupt pending.
- R9: A `frame_sync` cycle sets source-pending bit 1 and then ORs (source pending AND NOT mask) into interrupt pending.
- R10: A write to interrupt pending or to source pending replaces its value and merges nothing. Interrupt-pending bits clear only on a write to that register. `irq` is high exactly when interrupt pending is non-zero, and it follows a change from the next cycle.
- R11: A write to control 1, 2, 3 or 5, to frame-buffer word 1, to any lookup word or to the temporary palette raises `invalidate` for exactly the one cycle after the write.
- R12: A write to control 1 or 5, to any lookup word or to the temporary palette also raises `pal_reload` for the one cycle after the write. No other write raises either pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 12 | Byte offset of the access |
| wr_en | input | 1 | Write strobe, takes effect at the clock edge |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data for `addr` |
| frame_sync | input | 1 | Frame-sync event from the display engine |
| disp_on | output | 1 | Display enable flag |
| depth_mode | output | 4 | Pixel-depth mode |
| pal565 | output | 1 | Palette format is 5:6:5 |
| msb_first | output | 1 | MSB-first pixel order |
| invalidate | output | 1 | One-cycle pulse: redraw needed |
| pal_reload | output | 1 | One-cycle pulse: palette must be reloaded |
| irq | output | 1 | Interrupt request |

## Verification
Register storage is tested with an all-ones write, which shows each write mask and the always-one select bit, and with an alternating pattern, which shows that full-width words keep every bit. The interrupt unit is driven through an ordered sequence: a source write while masked, an unmask, a direct pending clear, a frame event while masked and a frame event while unmasked. This sequence separates a merge that happens at the trigger from a merge that follows the line continuously. The pulse test writes each offset once and separates registers that must pulse from registers that must stay quiet. The palette and unmapped tests use even and odd offsets and the edges of the palette window.

// File: rtl/disp_regbank.sv
module disp_regbank #(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  input  logic              frame_sync,
  output logic              disp_on,
  output logic [3:0]        depth_mode,
  output logic              pal565,
  output logic              msb_first,
  output logic              invalidate,
  output logic              pal_reload,
  output logic              irq
);

  localparam logic [4:0] W_CTL1 = 5'h00, W_CTL2 = 5'h01, W_CTL3 = 5'h02,
                         W_CTL4 = 5'h03, W_CTL5 = 5'h04, W_FBA1 = 5'h05,
                         W_FBA2 = 5'h06, W_FBA3 = 5'h07, W_LUTR = 5'h08,
                         W_LUTG = 5'h09, W_LUTB = 5'h0A, W_DITH = 5'h13,
                         W_TPAL = 5'h14, W_PEND = 5'h15, W_SRC  = 5'h16,
                         W_MSK  = 5'h17, W_LPC  = 5'h18;

  logic [17:0] ctl1_q;
  logic [31:0] ctl2_q, ctl3_q;
  logic [15:0] ctl4_q;
  logic [12:0] ctl5_q;
  logic [31:0] fba1_q, fba2_q, fba3_q;
  logic [31:0] lutr_q, lutg_q;
  logic [15:0] lutb_q;
  logic [31:0] dith_q, tpal_q;
  logic [1:0]  pend_q, src_q;
  logic [2:0]  msk_q;
  logic [1:0]  lpc_q;
  logic [15:0] pal_mem [256];

  wire       reg_hit = (addr[ADDR_W-1:7] == '0) && (addr[1:0] == 2'b00);
  wire       pal_hit = (addr[ADDR_W-1:9] == 'd2);
  wire [4:0] word    = addr[6:2];

  function automatic logic wr_at(input logic [4:0] w);
    return wr_en && reg_hit && (word == w);
  endfunction

  wire wr_inv = wr_at(W_CTL1) || wr_at(W_CTL2) || wr_at(W_CTL3) || wr_at(W_CTL5) ||
                wr_at(W_FBA1) || wr_at(W_LUTR) || wr_at(W_LUTG) || wr_at(W_LUTB) ||
                wr_at(W_TPAL);
  wire wr_rel = wr_at(W_CTL1) || wr_at(W_CTL5) || wr_at(W_LUTR) || wr_at(W_LUTG) ||
                wr_at(W_LUTB) || wr_at(W_TPAL);

  logic [1:0] pend_d, src_d;
  logic [2:0] msk_d;
  logic       merge;

  always_comb begin
    src_d  = wr_at(W_SRC)  ? wdata[1:0] : src_q;
    pend_d = wr_at(W_PEND) ? wdata[1:0] : pend_q;
    msk_d  = wr_at(W_MSK)  ? wdata[2:0] : msk_q;
    merge  = wr_at(W_MSK) || frame_sync;
    if (frame_sync) src_d[1] = 1'b1;
    if (merge) pend_d = pend_d | (src_d & ~msk_d[1:0]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl1_q <= '0; ctl2_q <= '0; ctl3_q <= '0; ctl4_q <= '0; ctl5_q <= '0;
      fba1_q <= '0; fba2_q <= '0; fba3_q <= '0;
      lutr_q <= '0; lutg_q <= '0; lutb_q <= '0;
      dith_q <= '0; tpal_q <= '0;
      pend_q <= '0; src_q <= '0; msk_q <= 3'd3; lpc_q <= '0;
      invalidate <= 1'b0; pal_reload <= 1'b0;
    end else begin
      if (wr_at(W_CTL1)) ctl1_q <= wdata[17:0];
      if (wr_at(W_CTL2)) ctl2_q <= wdata;
      if (wr_at(W_CTL3)) ctl3_q <= wdata;
      if (wr_at(W_CTL4)) ctl4_q <= wdata[15:0];
      if (wr_at(W_CTL5)) ctl5_q <= wdata[12:0];
      if (wr_at(W_FBA1)) fba1_q <= wdata;
      if (wr_at(W_FBA2)) fba2_q <= wdata;
      if (wr_at(W_FBA3)) fba3_q <= wdata;
      if (wr_at(W_LUTR)) lutr_q <= wdata;
      if (wr_at(W_LUTG)) lutg_q <= wdata;
      if (wr_at(W_LUTB)) lutb_q <= wdata[15:0];
      if (wr_at(W_DITH)) dith_q <= wdata;
      if (wr_at(W_TPAL)) tpal_q <= wdata;
      if (wr_at(W_LPC))  lpc_q  <= wdata[1:0];
      pend_q <= pend_d;
      src_q  <= src_d;
      msk_q  <= msk_d;
      invalidate <= wr_inv;
      pal_reload <= wr_rel;
    end
  end

  always_ff @(posedge clk)
    if (wr_en && pal_hit) pal_mem[addr[8:1]] <= wdata[15:0];

  always_comb begin
    rdata = '0;
    if (pal_hit) rdata = {16'h0, pal_mem[addr[8:1]]};
    else if (reg_hit) begin
      case (word)
        W_CTL1: rdata = {14'h0, ctl1_q};
        W_CTL2: rdata = ctl2_q;
        W_CTL3: rdata = ctl3_q;
        W_CTL4: rdata = {16'h0, ctl4_q};
        W_CTL5: rdata = {19'h0, ctl5_q};
        W_FBA1: rdata = fba1_q;
        W_FBA2: rdata = fba2_q;
        W_FBA3: rdata = fba3_q;
        W_LUTR: rdata = lutr_q;
        W_LUTG: rdata = lutg_q;
        W_LUTB: rdata = {16'h0, lutb_q};
        W_DITH: rdata = dith_q;
        W_TPAL: rdata = tpal_q;
        W_PEND: rdata = {30'h0, pend_q};
        W_SRC:  rdata = {30'h0, src_q};
        W_MSK:  rdata = {29'h0, msk_q};
        W_LPC:  rdata = {29'h0, 1'b1, lpc_q};
        default: rdata = '0;
      endcase
    end
  end

  assign disp_on    = ctl1_q[0];
  assign depth_mode = ctl1_q[4:1];
  assign pal565     = ctl5_q[11];
  assign msb_first  = ctl5_q[12];
  assign irq        = |pend_q;

  AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_at(W_PEND) |=> ((pend_q & $past(pend_q)) == $past(pend_q))); // R10
  AST_FRAME_SETS_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_sync && !wr_at(W_SRC)) |=> src_q[1]); // R9
  AST_MASK_MERGE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_at(W_MSK) && !wr_at(W_PEND)) |=> (($past(src_q) & ~$past(wdata[1:0]) & ~pend_q) == 2'b00)); // R8
  AST_RELOAD_IMPLIES_INV: assert property (@(posedge clk) disable iff (!rst_n)
    pal_reload |-> invalidate); // R12
  AST_SEL_BIT_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == ADDR_W'('h60)) |-> rdata[2]); // R4
  AST_IRQ_QUIET_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq && !wr_en && !frame_sync) |=> !irq); // R10

endmodule

// File: tb/sim_disp_regbank.sv
module sim_disp_regbank;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, frame_sync = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        disp_on, pal565, msb_first, invalidate, pal_reload, irq;
  logic [3:0]  depth_mode;
  logic        inv_seen, rel_seen;
  int          n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  disp_regbank u0 (.clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
    .rdata(rdata), .frame_sync(frame_sync), .disp_on(disp_on), .depth_mode(depth_mode),
    .pal565(pal565), .msb_first(msb_first), .invalidate(invalidate),
    .pal_reload(pal_reload), .irq(irq));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk); #1;
    inv_seen = invalidate; rel_seen = pal_reload;
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [11:0] a, input logic [31:0] exp);
    @(negedge clk); addr = a; #1;
    chk(tag, rdata, exp);
  endtask

  task automatic pulse_fs();
    @(negedge clk); frame_sync = 1'b1;
    @(posedge clk); #1; frame_sync = 1'b0;
  endtask

  task automatic t_reset();
    for (int i = 0; i < 25; i++) begin
      logic [11:0] a = 12'(i * 4);
      if (i == 23) rd_chk("R1 mask reset", a, 32'd3);
      else if (i == 24) rd_chk("R1 select reset", a, 32'd4);
      else rd_chk("R1 reg reset", a, 32'd0);
    end
    chk("R1 outputs idle", {25'h0, irq, disp_on, depth_mode, pal565}, 32'h0);
    chk("R1 pulses idle", {30'h0, invalidate, pal_reload}, 32'h0);
  endtask

  task automatic t_full_width();
    logic [11:0] offs [9] = '{12'h04, 12'h08, 12'h14, 12'h18, 12'h1C, 12'h20, 12'h24, 12'h4C, 12'h50};
    foreach (offs[i]) wr(offs[i], 32'hA5C3_0F96 ^ 32'(i));
    foreach (offs[i]) rd_chk("R2 full width", offs[i], 32'hA5C3_0F96 ^ 32'(i));
  endtask

  task automatic t_masks();
    wr(12'h00, '1); rd_chk("R3 ctl1 mask", 12'h00, 32'h0003_FFFF);
    wr(12'h0C, '1); rd_chk("R3 ctl4 mask", 12'h0C, 32'h0000_FFFF);
    wr(12'h10, '1); rd_chk("R3 ctl5 mask", 12'h10, 32'h0000_1FFF);
    wr(12'h28, '1); rd_chk("R3 blue mask", 12'h28, 32'h0000_FFFF);
    wr(12'h58, '1); rd_chk("R3 src mask", 12'h58, 32'h3);
    wr(12'h54, '1); rd_chk("R3 pend mask", 12'h54, 32'h3);
    chk("R10 irq follows pend write", {31'h0, irq}, 32'h1);
    wr(12'h5C, '1); rd_chk("R3 mask mask", 12'h5C, 32'h7);
    wr(12'h54, 32'h0); wr(12'h58, 32'h0); wr(12'h5C, 32'h3);
    chk("R10 irq clears on pend write", {31'h0, irq}, 32'h0);
  endtask

  task automatic t_decode();
    wr(12'h00, 32'h0000_001B);
    chk("R7 disp_on", {31'h0, disp_on}, 32'h1);
    chk("R7 depth_mode", {28'h0, depth_mode}, 32'hD);
    wr(12'h10, 32'h0000_0800);
    chk("R7 pal565/msb", {30'h0, pal565, msb_first}, 32'h2);
    wr(12'h10, 32'h0000_1000);
    chk("R7 msb only", {30'h0, pal565, msb_first}, 32'h1);
    wr(12'h00, 32'h0000_0004);
    chk("R7 disabled depth 2", {27'h0, disp_on, depth_mode}, 32'h02);
  endtask

  task automatic t_select();
    wr(12'h60, 32'hFF); rd_chk("R4 select all ones", 12'h60, 32'h7);
    wr(12'h60, 32'h2);  rd_chk("R4 select 2", 12'h60, 32'h6);
    wr(12'h60, 32'h0);  rd_chk("R4 select zero", 12'h60, 32'h4);
  endtask

  task automatic t_palette();
    wr(12'h400, 32'h1234_BEEF);
    wr(12'h402, 32'h0000_1111);
    wr(12'h5FE, 32'h0000_CAFE);
    rd_chk("R5 entry 0", 12'h400, 32'h0000_BEEF);
    rd_chk("R5 odd offset same entry", 12'h401, 32'h0000_BEEF);
    rd_chk("R5 entry 1", 12'h402, 32'h0000_1111);
    rd_chk("R5 last entry", 12'h5FE, 32'h0000_CAFE);
    wr(12'h5FF, 32'h0000_0042);
    rd_chk("R5 odd write last entry", 12'h5FE, 32'h0000_0042);
  endtask

  task automatic t_unmapped();
    wr(12'h28, 32'h0000_7777);
    wr(12'h2C, '1);  rd_chk("R6 hole reads zero", 12'h2C, 32'h0);
    rd_chk("R6 neighbour intact", 12'h28, 32'h0000_7777);
    wr(12'h2A, '1);  rd_chk("R6 unaligned", 12'h2A, 32'h0);
    rd_chk("R6 neighbour after unaligned", 12'h28, 32'h0000_7777);
    wr(12'h64, '1);  rd_chk("R6 past select", 12'h64, 32'h0);
    wr(12'h600, '1); rd_chk("R6 past palette", 12'h600, 32'h0);
    rd_chk("R6 palette intact", 12'h5FE, 32'h0000_0042);
  endtask

  task automatic t_irq();
    wr(12'h58, 32'h1);
    rd_chk("R10 src write no merge", 12'h54, 32'h0);
    chk("R10 irq low while masked", {31'h0, irq}, 32'h0);
    wr(12'h5C, 32'h2);
    rd_chk("R8 unmask merges bit0", 12'h54, 32'h1);
    chk("R8 irq after unmask", {31'h0, irq}, 32'h1);
    wr(12'h58, 32'h0);
    rd_chk("R10 pend sticky after src clear", 12'h54, 32'h1);
    wr(12'h54, 32'h0);
    chk("R10 irq drops", {31'h0, irq}, 32'h0);
    wr(12'h5C, 32'h3);
    pulse_fs();
    rd_chk("R9 frame sets src bit1", 12'h58, 32'h2);
    rd_chk("R9 masked frame no pend", 12'h54, 32'h0);
    wr(12'h5C, 32'h1);
    rd_chk("R8 unmask merges bit1", 12'h54, 32'h2);
    chk("R8 irq bit1", {31'h0, irq}, 32'h1);
    wr(12'h54, 32'h0); wr(12'h58, 32'h0); wr(12'h5C, 32'h0);
    rd_chk("R8 mask write empty src", 12'h54, 32'h0);
    pulse_fs();
    rd_chk("R9 unmasked frame merges", 12'h54, 32'h2);
    chk("R9 irq on frame", {31'h0, irq}, 32'h1);
    wr(12'h54, 32'h0); wr(12'h5C, 32'h3);
  endtask

  task automatic t_pulses();
    logic [11:0] offs [14] = '{12'h00, 12'h04, 12'h08, 12'h0C, 12'h10, 12'h14, 12'h18,
                               12'h1C, 12'h20, 12'h24, 12'h28, 12'h4C, 12'h50, 12'h60};
    logic [1:0]  exp  [14] = '{2'b11, 2'b10, 2'b10, 2'b00, 2'b11, 2'b10, 2'b00,
                               2'b00, 2'b11, 2'b11, 2'b11, 2'b00, 2'b11, 2'b00};
    foreach (offs[i]) begin
      wr(offs[i], 32'h0);
      chk($sformatf("R11 R12 pulses after write %h", offs[i]), {30'h0, inv_seen, rel_seen}, {30'h0, exp[i]});
    end
    wr(12'h00, 32'h0);
    @(posedge clk); #1;
    chk("R11 R12 pulse lasts one cycle", {30'h0, invalidate, pal_reload}, 32'h0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_full_width();
        t_masks();
        t_decode();
        t_select();
        t_palette();
        t_unmapped();
        t_irq();
        t_pulses();
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    disable fork;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule